// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the ROM-level command decoder of a single-wire bus slave. A bit-slot engine in front of it detects reset pulses and hands over one strobe per completed time slot, together with the level sampled in that slot. After every line reset the layer assembles an 8-bit command, least significant bit first. It then runs the addressing step that the command selects: it sends the 64-bit registration number, compares an incoming number against it, takes part in a bit-by-bit search, or skips addressing entirely. When addressing succeeds, it hands the bus to the memory-function layer by raising `fn_enable`.

Two flags persist across commands. The resume flag remembers that this slave was the last one singled out by address. The overdrive flag selects the fast slot timing in the bit-slot engine. A long line reset returns the slave to standard speed. A short reset keeps the current speed.

FSM states and transitions:
- `ST_IDLE` waits for a line reset. It is entered on an unknown command, a refused resume, a failed match or a search drop-out.
- `ST_CMD` collects the command byte. It is entered on every line reset.
- `ST_READ` sends the number.
- `ST_MATCH` receives and compares the number.
- `ST_SRCH_TRUE`, `ST_SRCH_CMP` and `ST_SRCH_DIR` are the three slots of each search bit.
- `ST_FUNC` marks a handed-over bus. It is entered after a completed read, match or search, and on skip, overdrive skip, or resume with the flag set.

Top module: `ow_rom_layer`

## Requirements
- R1: After `rst_n` is low, `od_mode`, `fn_enable` and `tx_en` are 0. Bit strobes are ignored until the first `line_rst`.
- R2: After each `line_rst` the next 8 bit strobes form a command, first bit into bit 0. Any code other than 33h, 55h, F0h, CCh, A5h, 3Ch or 69h sends the layer to `ST_IDLE`, where `fn_enable` and `tx_en` stay 0 until the next `line_rst`.
- R3: Command 33h drives `tx_en`=1 with `tx_bit` = `reg_id[i]` for slots i = 0..63 in order. `fn_enable` rises in the cycle after the 64th strobe.
- R4: Command CCh raises `fn_enable` in the cycle after the 8th command strobe.
- R5: Command 55h compares 64 received bits with `reg_id`, bit 0 first. A full match raises `fn_enable` and sets the resume flag. Any mismatch leads to `ST_IDLE` and clears the resume flag.
- R6: Command F0h repeats three slots per bit i. The first slot sends `reg_id[i]` (`tx_en`=1), the second sends its inverse (`tx_en`=1), and the third reads the master's choice (`tx_en`=0). A choice unequal to `reg_id[i]` drops to `ST_IDLE` and clears the resume flag. Completing bit 63 raises `fn_enable` and sets the flag.
- R7: Command A5h raises `fn_enable` if the resume flag is set. Otherwise it leads to `ST_IDLE`.
- R8: Command 3Ch sets `od_mode` and raises `fn_enable` in the cycle after the 8th command strobe.
- R9: Command 69h sets `od_mode` in the cycle after the 8th command strobe, then compares 64 bits as in R5. On a mismatch, `od_mode` returns after the 64th bit to its value from before the command, so a slave already in overdrive keeps it.
- R10: A `line_rst` with `rst_long`=1 clears `od_mode`. A `line_rst` with `rst_long`=0 leaves it unchanged.
- R11: A `line_rst` aborts any state in the next cycle and enters `ST_CMD`. A bit strobe in the same cycle is not taken as a command bit.
- R12: In `ST_FUNC`, bit strobes leave `fn_enable`=1, `tx_en`=0 and `od_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_id | input | ID_W | Registration number of this slave |
| line_rst | input | 1 | One-cycle strobe: reset pulse detected on the line |
| rst_long | input | 1 | Qualifier of `line_rst`: pulse was long enough to leave overdrive |
| bit_stb | input | 1 | One-cycle strobe: a time slot completed |
| rx_bit | input | 1 | Line level sampled in that slot |
| od_mode | output | 1 | Overdrive speed selected |
| fn_enable | output | 1 | Bus handed to the memory-function layer |
| tx_en | output | 1 | Current slot is a transmit slot of this layer |
| tx_bit | output | 1 | Bit to send in the current slot (0 = pull low) |

## Verification
A wrong state shows at the ports within one slot. A wrong transmit state makes `tx_en` or `tx_bit` disagree at the next read slot. A wrong hand-over makes `fn_enable` differ in the cycle after the deciding strobe. Errors in the resume and overdrive flags stay hidden until a later command consults them. The bench therefore follows every match, search and overdrive match with a resume or a reset of each length, so a stale or lost flag shows up one command later as a wrong `fn_enable` or `od_mode`.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CODE_READ     = 8'h33;
    localparam logic [CMD_W-1:0] CODE_MATCH    = 8'h55;
    localparam logic [CMD_W-1:0] CODE_SEARCH   = 8'hF0;
    localparam logic [CMD_W-1:0] CODE_SKIP     = 8'hCC;
    localparam logic [CMD_W-1:0] CODE_RESUME   = 8'hA5;
    localparam logic [CMD_W-1:0] CODE_OD_SKIP  = 8'h3C;
    localparam logic [CMD_W-1:0] CODE_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_CMP,
        ST_SRCH_DIR,
        ST_FUNC
    } rom_state_e;
endpackage

// File: rtl/ow_cmd_rx.sv
module ow_cmd_rx #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_in,
    output logic             done,
    output logic [CMD_W-1:0] code
);
    localparam int CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    logic [CMD_W-1:0] sreg;
    logic [CNT_W-1:0] cnt;

    // first bit received ends up in bit 0
    assign code = {bit_in, sreg[CMD_W-1:1]};
    assign done = shift && (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (clear) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (shift) begin
            sreg <= code;
            cnt  <= done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ow_bit_idx.sv
module ow_bit_idx #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 inc,
    output logic [$clog2(N)-1:0] idx,
    output logic                 last
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] IDX_LAST = IW'(N - 1);

    assign last = (idx == IDX_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clear)
            idx <= '0;
        else if (inc && !last)
            idx <= idx + 1'b1;
    end
endmodule

// File: rtl/ow_flag_ctl.sv
module ow_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic long_rst,
    input  logic od_set,
    input  logic od_restore,
    input  logic rc_set,
    input  logic rc_clr,
    output logic od,
    output logic rc
);
    logic od_saved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            od       <= 1'b0;
            od_saved <= 1'b0;
        end else if (long_rst) begin
            od       <= 1'b0;
        end else if (od_set) begin
            od_saved <= od;
            od       <= 1'b1;
        end else if (od_restore) begin
            od       <= od_saved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rc <= 1'b0;
        else if (rc_clr)
            rc <= 1'b0;
        else if (rc_set)
            rc <= 1'b1;
    end
endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
    import ow_rom_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] reg_id,
    input  logic            line_rst,
    input  logic            rst_long,
    input  logic            bit_stb,
    input  logic            rx_bit,
    output logic            od_mode,
    output logic            fn_enable,
    output logic            tx_en,
    output logic            tx_bit
);
    localparam int IW = $clog2(ID_W);

    rom_state_e       state, nxt;
    logic             bit_go;
    logic             cmd_shift, cmd_done;
    logic [CMD_W-1:0] cmd_code;
    logic [IW-1:0]    idx;
    logic             idx_last, idx_clr, idx_inc;
    logic             id_bit, bit_diff;
    logic             mis_q, om_q;
    logic             od_set, od_restore, rc_set, rc_clr;
    logic             rc_q;

    assign bit_go    = bit_stb && !line_rst;
    assign cmd_shift = bit_go && (state == ST_CMD);
    assign id_bit    = reg_id[idx];
    assign bit_diff  = (rx_bit != id_bit);

    ow_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (line_rst),
        .shift  (cmd_shift),
        .bit_in (rx_bit),
        .done   (cmd_done),
        .code   (cmd_code)
    );

    ow_bit_idx #(.N(ID_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idx_clr),
        .inc   (idx_inc),
        .idx   (idx),
        .last  (idx_last)
    );

    ow_flag_ctl u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .long_rst   (line_rst && rst_long),
        .od_set     (od_set),
        .od_restore (od_restore),
        .rc_set     (rc_set),
        .rc_clr     (rc_clr),
        .od         (od_mode),
        .rc         (rc_q)
    );

    // next state and control strobes
    always_comb begin
        nxt        = state;
        idx_clr    = 1'b0;
        idx_inc    = 1'b0;
        od_set     = 1'b0;
        od_restore = 1'b0;
        rc_set     = 1'b0;
        rc_clr     = 1'b0;
        if (line_rst) begin
            nxt     = ST_CMD;
            idx_clr = 1'b1;
        end else if (bit_stb) begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_FUNC: nxt = ST_FUNC;
                ST_CMD: begin
                    if (cmd_done) begin
                        idx_clr = 1'b1;
                        case (cmd_code)
                            CODE_READ:     nxt = ST_READ;
                            CODE_MATCH:    nxt = ST_MATCH;
                            CODE_SEARCH:   nxt = ST_SRCH_TRUE;
                            CODE_SKIP:     nxt = ST_FUNC;
                            CODE_RESUME:   nxt = rc_q ? ST_FUNC : ST_IDLE;
                            CODE_OD_SKIP: begin
                                nxt    = ST_FUNC;
                                od_set = 1'b1;
                            end
                            CODE_OD_MATCH: begin
                                nxt    = ST_MATCH;
                                od_set = 1'b1;
                            end
                            default:       nxt = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: begin
                    idx_inc = 1'b1;
                    if (idx_last)
                        nxt = ST_FUNC;
                end
                ST_MATCH: begin
                    idx_inc = 1'b1;
                    if (idx_last) begin
                        if (mis_q || bit_diff) begin
                            nxt        = ST_IDLE;
                            rc_clr     = 1'b1;
                            od_restore = om_q;
                        end else begin
                            nxt    = ST_FUNC;
                            rc_set = 1'b1;
                        end
                    end
                end
                ST_SRCH_TRUE: nxt = ST_SRCH_CMP;
                ST_SRCH_CMP:  nxt = ST_SRCH_DIR;
                ST_SRCH_DIR: begin
                    if (bit_diff) begin
                        nxt    = ST_IDLE;
                        rc_clr = 1'b1;
                    end else if (idx_last) begin
                        nxt    = ST_FUNC;
                        rc_set = 1'b1;
                    end else begin
                        idx_inc = 1'b1;
                        nxt     = ST_SRCH_TRUE;
                    end
                end
            endcase
        end
    end

    // state register with match bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mis_q <= 1'b0;
            om_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (idx_clr)
                mis_q <= 1'b0;
            else if (bit_go && state == ST_MATCH)
                mis_q <= mis_q | bit_diff;
            if (line_rst)
                om_q <= 1'b0;
            else if (cmd_done)
                om_q <= (cmd_code == CODE_OD_MATCH);
        end
    end

    // outputs decoded from the current state
    always_comb begin
        fn_enable = 1'b0;
        tx_en     = 1'b0;
        tx_bit    = 1'b1;
        unique case (state)
            ST_FUNC: fn_enable = 1'b1;
            ST_READ, ST_SRCH_TRUE: begin
                tx_en  = 1'b1;
                tx_bit = id_bit;
            end
            ST_SRCH_CMP: begin
                tx_en  = 1'b1;
                tx_bit = ~id_bit;
            end
            ST_IDLE, ST_CMD, ST_MATCH, ST_SRCH_DIR: begin
                tx_en  = 1'b0;
                tx_bit = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ow_rom_layer_chk.sv
module ow_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic line_rst,
    input logic rst_long,
    input logic bit_stb,
    input logic od_mode,
    input logic fn_enable,
    input logic tx_en,
    input logic rc
);
    assert_long_rst_std_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst && rst_long |=> !od_mode);

    assert_short_rst_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst && !rst_long |=> od_mode == $past(od_mode));

    assert_rst_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |=> !fn_enable && !tx_en);

    assert_func_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fn_enable |-> !tx_en);

    assert_func_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fn_enable && !line_rst |=> fn_enable && od_mode == $past(od_mode));

    assert_od_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_mode) |-> $past(bit_stb) && !$past(line_rst));

    assert_rc_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc) |-> $rose(fn_enable));
endmodule

bind ow_rom_layer ow_rom_layer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_rst  (line_rst),
    .rst_long  (rst_long),
    .bit_stb   (bit_stb),
    .od_mode   (od_mode),
    .fn_enable (fn_enable),
    .tx_en     (tx_en),
    .rc        (rc_q)
);

// File: tb/ow_rom_layer_test.sv
module ow_rom_layer_test;
    localparam logic [63:0] ID = 64'h5C3A_91E7_0B24_D86F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_rst = 1'b0;
    logic rst_long = 1'b0;
    logic bit_stb = 1'b0;
    logic rx_bit = 1'b1;
    logic od_mode, fn_enable, tx_en, tx_bit;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    string      tag_q[$];
    logic [4:0] val_q[$];

    always #5 clk = ~clk;

    ow_rom_layer #(.ID_W(64)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_id    (ID),
        .line_rst  (line_rst),
        .rst_long  (rst_long),
        .bit_stb   (bit_stb),
        .rx_bit    (rx_bit),
        .od_mode   (od_mode),
        .fn_enable (fn_enable),
        .tx_en     (tx_en),
        .tx_bit    (tx_bit)
    );

    // monitor: pops expectations and compares {od, fn, tx_en, tx_bit}
    always @(negedge clk) begin
        if (tag_q.size() > 0) begin
            string      t;
            logic [4:0] e;
            logic [3:0] act, msk;
            t   = tag_q.pop_front();
            e   = val_q.pop_front();
            act = {od_mode, fn_enable, tx_en, tx_bit};
            msk = {3'b111, e[0]};
            n_chk++;
            if ((act & msk) !== (e[4:1] & msk)) begin
                n_err++;
                $display("FAIL %s: actual od/fn/te/tb=%b expected=%b (mask %b)",
                         t, act, e[4:1], msk);
            end
        end
    end

    task automatic chk(input string t, input logic od, input logic fn,
                       input logic te, input logic tb, input logic care);
        tag_q.push_back(t);
        val_q.push_back({od, fn, te, tb, care});
        @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        bit_stb = 1'b1;
        rx_bit  = b;
        @(negedge clk);
        bit_stb = 1'b0;
        rx_bit  = 1'b1;
    endtask

    task automatic lreset(input logic lng);
        line_rst = 1'b1;
        rst_long = lng;
        @(negedge clk);
        line_rst = 1'b0;
        rst_long = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) pulse(b[i]);
    endtask

    task automatic send_id(input logic [63:0] v);
        for (int i = 0; i < 64; i++) pulse(v[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", 0, 0, 0, 1, 0);
        send_byte(8'hCC);
        chk("R1 strobes ignored before line reset", 0, 0, 0, 1, 0);

        // R4 skip, then R12 strobes ignored in function state
        lreset(1);
        send_byte(8'hCC);
        chk("R4 skip hands over", 0, 1, 0, 1, 0);
        send_byte(8'h3C);
        chk("R12 function state ignores strobes", 0, 1, 0, 1, 0);

        // R3 read
        lreset(1);
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) begin
            chk("R3 read bit", 0, 0, 1, ID[i], 1);
            pulse(1'b1);
        end
        chk("R3 read hands over", 0, 1, 0, 1, 0);

        // R7 resume refused, R2 idle
        lreset(1);
        send_byte(8'hA5);
        chk("R7 resume refused without flag", 0, 0, 0, 1, 0);
        send_byte(8'hCC);
        chk("R2 idle after refused resume", 0, 0, 0, 1, 0);

        // R5 match success then resume
        lreset(1);
        send_byte(8'h55);
        chk("R5 match awaiting address", 0, 0, 0, 1, 0);
        send_id(ID);
        chk("R5 match hands over", 0, 1, 0, 1, 0);
        lreset(1);
        send_byte(8'hA5);
        chk("R7 resume after match", 0, 1, 0, 1, 0);

        // R5 mismatch clears flag
        lreset(1);
        send_byte(8'h55);
        send_id(ID ^ (64'd1 << 40));
        chk("R5 mismatch goes idle", 0, 0, 0, 1, 0);
        lreset(1);
        send_byte(8'hA5);
        chk("R5 mismatch cleared resume flag", 0, 0, 0, 1, 0);

        // R2 unknown code
        lreset(1);
        send_byte(8'h96);
        chk("R2 unknown code idle", 0, 0, 0, 1, 0);
        send_byte(8'hCC);
        chk("R2 idle until next reset", 0, 0, 0, 1, 0);

        // R6 full search
        lreset(1);
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            chk("R6 search true slot", 0, 0, 1, ID[i], 1);
            pulse(1'b1);
            chk("R6 search complement slot", 0, 0, 1, ~ID[i], 1);
            pulse(1'b1);
            chk("R6 search choice slot", 0, 0, 0, 1, 0);
            pulse(ID[i]);
        end
        chk("R6 search hands over", 0, 1, 0, 1, 0);
        lreset(1);
        send_byte(8'hA5);
        chk("R7 resume after search", 0, 1, 0, 1, 0);

        // R6 search drop-out
        lreset(1);
        send_byte(8'hF0);
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1); pulse(1'b1); pulse(ID[i]);
        end
        pulse(1'b1); pulse(1'b1); pulse(~ID[5]);
        chk("R6 drop-out idle", 0, 0, 0, 1, 0);
        pulse(1'b1);
        chk("R6 no transmit after drop-out", 0, 0, 0, 1, 0);
        lreset(1);
        send_byte(8'hA5);
        chk("R6 drop-out cleared resume flag", 0, 0, 0, 1, 0);

        // R8 overdrive skip, R10 short reset
        lreset(1);
        send_byte(8'h3C);
        chk("R8 overdrive skip", 1, 1, 0, 1, 0);
        lreset(0);
        chk("R10 short reset keeps overdrive", 1, 0, 0, 1, 0);

        // R9 overdrive match mismatch while already fast
        send_byte(8'h69);
        chk("R9 overdrive set by command", 1, 0, 0, 1, 0);
        send_id(~ID);
        chk("R9 prior overdrive kept on mismatch", 1, 0, 0, 1, 0);
        lreset(1);
        chk("R10 long reset clears overdrive", 0, 0, 0, 1, 0);

        // R9 from standard speed, mismatch
        send_byte(8'h69);
        chk("R9 overdrive after command byte", 1, 0, 0, 1, 0);
        send_id(ID ^ 64'd1);
        chk("R9 mismatch returns to standard", 0, 0, 0, 1, 0);

        // R9 match
        lreset(1);
        send_byte(8'h69);
        send_id(ID);
        chk("R9 overdrive match hands over", 1, 1, 0, 1, 0);
        lreset(0);
        send_byte(8'hA5);
        chk("R7 resume after overdrive match", 1, 1, 0, 1, 0);

        // R11 abort with simultaneous strobe
        lreset(1);
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) pulse(1'b1);
        line_rst = 1'b1;
        bit_stb  = 1'b1;
        rx_bit   = 1'b0;
        @(negedge clk);
        line_rst = 1'b0;
        bit_stb  = 1'b0;
        rx_bit   = 1'b1;
        chk("R11 reset aborts read", 0, 0, 0, 1, 0);
        send_byte(8'hCC);
        chk("R11 coincident strobe not a command bit", 0, 1, 0, 1, 0);

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog R11: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule